// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block collects 32 raw interrupt lines and turns them into two processor-facing requests: a normal interrupt and a fast interrupt. Every line can be set to level or edge sensitivity and to either polarity. Each raw line is first passed through a two-flop synchronizer. In level mode, a line's status bit follows the synchronized line. In edge mode, the detected edge is held in a per-line latch until software clears it by writing ones.

Software controls the block through a word-addressed 32-bit register port. It sets the mask, the sensitivity and polarity of each line, and the route of each line to the normal or the fast output. It can read back the raw status, the pending set (status with masked lines removed) and a next-source word. The next-source word gives the lowest-numbered pending line. Reads are combinational from the address. Writes take effect at the clock edge where `regWrEn` is sampled high.

Top module: `intc_top`

## Requirements
- R1: After reset the mask register (address 0) reads all ones. The mode (1), polarity (2) and fast-select (3) registers read zero. Status (5), pending (6) and next-source (7) read zero, and both outputs are low.
- R2: A line in level mode (mode bit 0) with polarity bit 0 sets its status bit while the line is high. The bit reads 0 one clock after the line rises and 1 two clocks after.
- R3: A line in level mode with polarity bit 1 shows in status while the line is low.
- R4: A line in edge mode (mode bit 1) with polarity bit 0 latches a rising edge into status. The bit stays set after the line returns low.
- R5: A line in edge mode with polarity bit 1 latches a falling edge into status.
- R6: Writing to the edge-clear register (address 4) clears the latched edges of the lines whose bits are written 1. Bits written 0 are left unchanged, and the register reads back zero.
- R7: Pending (address 6) equals status AND NOT mask; a mask bit of 1 blocks the line from both outputs.
- R8: `fastOut` is the OR of the pending lines whose fast-select bit is 1. `irqOut` is the OR of the pending lines whose fast-select bit is 0.
- R9: Next-source (address 7) holds the index of the lowest-numbered pending line in bits [4:0] and a valid flag in bit 31. It reads zero when nothing is pending.
- R10: Switching a line from edge to level mode discards its latched edge, so it is not seen after a later switch back to edge mode.
- R11: Status, pending and next-source are read-only, so writes to them change no state. A single write updates at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 32 | Raw interrupt lines, asynchronous to clk |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Normal interrupt request |
| fastOut | output | 1 | Fast interrupt request |

## Verification
A table of five configurations drives all 32 lines at once. Two of them use level mode with each polarity. Two use edge mode with each polarity, and the line pattern is chosen so that rising and falling transitions both happen on different bits. This separates a polarity mix-up from a mode mix-up. The fifth mixes modes and polarities across byte lanes, which exposes any bit of one register leaking into the neighbouring lane of another. Directed tests follow. They count the two-clock synchronizer delay, clear edges partially, switch modes while a latch is full, send one line to each output, and use several pending lines to confirm the lowest index wins, including line 31 alone.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MASK   = 3'd0,
    ADDR_MODE   = 3'd1,
    ADDR_POL    = 3'd2,
    ADDR_FAST   = 3'd3,
    ADDR_CLR    = 3'd4,
    ADDR_STATUS = 3'd5,
    ADDR_PEND   = 3'd6,
    ADDR_NEXT   = 3'd7
  } regAddrE;

  typedef struct packed {
    logic wrMask;
    logic wrMode;
    logic wrPol;
    logic wrFast;
    logic wrClr;
  } regStrobeS;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobeS         strobes,
  output regAddrE           rdSel
);
  regAddrE addrDec;

  always_comb begin
    addrDec = regAddrE'(regAddr);
    rdSel   = addrDec;
    strobes = '0;
    if (regWrEn) begin
      unique case (addrDec)
        ADDR_MASK: strobes.wrMask = 1'b1;
        ADDR_MODE: strobes.wrMode = 1'b1;
        ADDR_POL:  strobes.wrPol  = 1'b1;
        ADDR_FAST: strobes.wrFast = 1'b1;
        ADDR_CLR:  strobes.wrClr  = 1'b1;
        default:   strobes        = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobeS          strobes,
  input  regAddrE            rdSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fastOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncStg;
  logic [NUM_SRC-1:0] srcSync, prevSync;
  logic [NUM_SRC-1:0] maskReg, modeReg, polReg, fastReg, latchReg;
  logic [NUM_SRC-1:0] riseVec, fallVec, edgeHit, clrVec, latchNext;
  logic [NUM_SRC-1:0] levelActive, statusVec, pendVec;
  logic [IDX_W-1:0]   nextIdx;
  logic               nextValid;

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStg <= '0;
    end else begin
      syncStg[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStg[s] <= syncStg[s-1];
    end
  end

  assign srcSync = syncStg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSync <= '0;
    else       prevSync <= srcSync;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '1;
      modeReg <= '0;
      polReg  <= '0;
      fastReg <= '0;
    end else begin
      if (strobes.wrMask) maskReg <= wrData[NUM_SRC-1:0];
      if (strobes.wrMode) modeReg <= wrData[NUM_SRC-1:0];
      if (strobes.wrPol)  polReg  <= wrData[NUM_SRC-1:0];
      if (strobes.wrFast) fastReg <= wrData[NUM_SRC-1:0];
    end
  end

  // edge detection on the synchronized line, so polarity changes cause no edge
  always_comb begin
    riseVec   = srcSync & ~prevSync;
    fallVec   = ~srcSync & prevSync;
    edgeHit   = (riseVec & ~polReg) | (fallVec & polReg);
    clrVec    = strobes.wrClr ? wrData[NUM_SRC-1:0] : '0;
    latchNext = modeReg & (edgeHit | (latchReg & ~clrVec));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchReg <= '0;
    else       latchReg <= latchNext;
  end

  always_comb begin
    levelActive = srcSync ^ polReg;
    statusVec   = (modeReg & latchReg) | (~modeReg & levelActive);
    pendVec     = statusVec & ~maskReg;
    irqOut      = |(pendVec & ~fastReg);
    fastOut     = |(pendVec & fastReg);
  end

  // lowest-index encoder: descending scan so the smallest set index is kept
  always_comb begin
    nextIdx   = '0;
    nextValid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        nextIdx   = i[IDX_W-1:0];
        nextValid = 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      ADDR_MASK:   rdData = DATA_W'(maskReg);
      ADDR_MODE:   rdData = DATA_W'(modeReg);
      ADDR_POL:    rdData = DATA_W'(polReg);
      ADDR_FAST:   rdData = DATA_W'(fastReg);
      ADDR_STATUS: rdData = DATA_W'(statusVec);
      ADDR_PEND:   rdData = DATA_W'(pendVec);
      ADDR_NEXT: begin
        rdData[DATA_W-1]  = nextValid;
        rdData[IDX_W-1:0] = nextIdx;
      end
      default:     rdData = '0;
    endcase
  end

  // a latch bit can only be full if its line was in edge mode the cycle before
  assert_latch_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((latchReg & ~$past(modeReg)) == '0));

  // a full latch with no clear stays full while in edge mode
  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(latchReg) & $past(modeReg) & ~$past(clrVec)) & ~latchReg) == '0));

  // a single write reaches at most one register
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // encoder valid agrees with the output OR trees
  assert_next_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    nextValid == (irqOut | fastOut));

  // all lines masked keeps both requests quiet
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (&maskReg) |-> (!irqOut && !fastOut));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut,
  output logic               fastOut
);
  regStrobeS strobes;
  regAddrE   rdSel;

  intc_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  intc_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .fastOut (fastOut)
  );
endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut, fastOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc_top u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .fastOut(fastOut)
  );

  // entry: mode, polarity, first lines, second lines, expected status
  localparam logic [159:0] VECS [5] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF, 32'hFFFF_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h00F0_00F0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'h0F00_0F00},
    {32'hFFFF_0000, 32'h00FF_00FF, 32'h0000_0000, 32'hF0F0_F0F0, 32'hF000_F00F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] nextWord(input logic [31:0] pend);
    logic [31:0] w = '0;
    for (int i = 31; i >= 0; i--) if (pend[i]) w = 32'h8000_0000 | 32'(i);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    string tag;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    rd(0, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(1, v); check("R1 mode", v, 32'h0);
    rd(2, v); check("R1 polarity", v, 32'h0);
    rd(3, v); check("R1 fast", v, 32'h0);
    rd(7, v); check("R1 next", v, 32'h0);
    check("R1 outputs", {30'd0, irqOut, fastOut}, 32'h0);

    // R2 synchronizer latency, level high
    @(negedge clk); regAddr = 3'd5; srcIn = 32'h1;
    @(negedge clk); check("R2 one clock", regRdData, 32'h0);
    @(negedge clk); check("R2 two clocks", regRdData, 32'h1);
    srcIn = '0;
    idle(4);

    // table walk
    for (int e = 0; e < 5; e++) begin
      case (e)
        0: tag = "R2 level high";
        1: tag = "R3 level low";
        2: tag = "R4 rising edge";
        3: tag = "R5 falling edge";
        default: tag = "R3 R4 R5 mixed lanes";
      endcase
      srcIn = VECS[e][95:64];
      idle(5);
      wr(1, VECS[e][159:128]);
      wr(2, VECS[e][127:96]);
      wr(4, 32'hFFFF_FFFF);
      srcIn = VECS[e][63:32];
      idle(5);
      exp = VECS[e][31:0];
      rd(5, v); check(tag, v, exp);
      wr(0, 32'h0);
      rd(6, v); check({"R7 pending ", tag}, v, exp);
      check({"R8 irq ", tag}, {31'd0, irqOut}, {31'd0, exp != 0});
      rd(7, v); check({"R9 next ", tag}, v, nextWord(exp));
      wr(0, 32'hFFFF_FFFF);
    end

    // R6 partial clear, R4 hold
    srcIn = '0;
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'h0);
    idle(5);
    wr(4, 32'hFFFF_FFFF);
    srcIn = 32'h0000_000F;
    idle(5);
    rd(5, v); check("R4 latched", v, 32'h0000_000F);
    wr(4, 32'h0000_0005);
    rd(5, v); check("R6 partial clear", v, 32'h0000_000A);
    rd(4, v); check("R6 reads zero", v, 32'h0);
    srcIn = '0;
    idle(5);
    rd(5, v); check("R4 hold after line low", v, 32'h0000_000A);

    // R10 mode switch discards latch
    wr(1, 32'h0);
    rd(5, v); check("R10 level view", v, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    rd(5, v); check("R10 latch discarded", v, 32'h0);

    // R7 masking and R8 routing
    wr(1, 32'h0);
    srcIn = 32'h0000_0300;
    idle(5);
    rd(6, v); check("R7 all masked", v, 32'h0);
    check("R7 quiet", {30'd0, irqOut, fastOut}, 32'h0);
    wr(0, ~32'h0000_0100);
    rd(6, v); check("R7 one unmasked", v, 32'h0000_0100);
    check("R8 normal route", {30'd0, irqOut, fastOut}, 32'h2);
    wr(3, 32'h0000_0100);
    check("R8 fast route", {30'd0, irqOut, fastOut}, 32'h1);
    wr(3, 32'h0000_0200);
    check("R8 other line fast", {30'd0, irqOut, fastOut}, 32'h2);
    wr(3, 32'h0);

    // R9 lowest index
    wr(0, 32'h0);
    srcIn = 32'h0000_0220;
    idle(5);
    rd(7, v); check("R9 lowest of two", v, 32'h8000_0005);
    srcIn = 32'h8000_0000;
    idle(5);
    rd(7, v); check("R9 line 31", v, 32'h8000_001F);
    srcIn = '0;
    idle(5);
    rd(7, v); check("R9 none pending", v, 32'h0);

    // R11 read-only registers
    wr(5, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    rd(5, v); check("R11 status unchanged", v, 32'h0);
    rd(0, v); check("R11 mask unchanged", v, 32'h0);
    rd(1, v); check("R11 mode unchanged", v, 32'h0);
    check("R11 outputs quiet", {30'd0, irqOut, fastOut}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule